// File: doc/BRIEF.md
# Accumulator-Based 8-bit Processor Core

This block is a small single-cycle processor. It holds its program in a 16-word instruction store and its data in a 16-entry register file. Every instruction is one byte: the low nibble selects the operation and the high nibble is the only operand. Depending on the operation, that operand is a register number, a signed 4-bit constant or an absolute jump address. Arithmetic and logic results always land in an 8-bit accumulator. The accumulator is also the first ALU input. The sa operation copies the accumulator into a register.

A 2-bit mode input sets what the core does:

- Mode 00 leaves the core alone.
- Mode 10 loads the instruction store, one byte per load strobe.
- Mode 01 loads the register file the same way.
- Mode 11 starts a run from address 0.

A run ends when the program counter steps past address 15. The done output then rises again. Two register numbers do not address storage. Number 14 returns the byte last received by an external serial engine. Number 15 returns a one-bit frame flag from an external timer. Loading the accumulator from number 15 also pulses a reload strobe that re-arms that timer.

Two operations hand a byte to the serial engine or fetch one from it. The program counter holds still until the engine reports that it is no longer busy.

Top module: `tacc_core`

## Requirements
- R1: An instruction is decoded as opcode = bits [3:0] and operand field = bits [7:4]. The opcode values are: 0 add, 1 reserved, 2 and, 3 la, 4 or, 5 xor, 6 srl, 7 sll, 8 addi, 9 li, 10 sout, 11 sin, 12 sa, 13 bnez, 14 beqz, 15 jmp.
- R2: Register-operand ALU operations replace the accumulator A with a value computed from B, the selected register:
  - add gives A+B (mod 256).
  - and, or and xor give the bitwise result.
  - la gives B.
  - srl gives A >> B[2:0].
  - sll gives A << B[2:0].
- R3: addi sets the accumulator to A plus the sign-extended 4-bit field (mod 256). li loads the sign-extended field into the accumulator.
- R4: Operand number 14 reads the serial engine's receive byte. Operand number 15 reads the frame flag, zero-extended to 8 bits.
- R5: sa writes the accumulator into registers 0–13. Writes to numbers 14 and 15, whether from sa or in load mode, change nothing.
- R6: bnez jumps to the field address when the accumulator is non-zero. beqz jumps when it is zero. jmp always jumps. Otherwise the PC advances by 1.
- R7: sout and sin raise ser_req for exactly one cycle. ser_wr is 1 for sout and 0 for sin. For sout, ser_wdata carries the value of the operand register. The PC then holds until ser_busy is low again. With a busy time of B cycles, each such operation costs B+1 extra cycles.
- R8: Executing la with operand 15 raises fc_reload for one cycle. No other instruction raises it.
- R9: Loading and starting work as follows:
  - With mode 10, a load strobe writes ld_data into the instruction store at ld_addr.
  - With mode 01, a load strobe writes ld_data into the register file at ld_addr.
  - With mode 00, a load strobe writes nothing.
  - With mode 11, execution starts at address 0.
- R10: A run without taken branches lasts 16 cycles. done is low during a run. After the PC wraps from 15 to 0, done stays high until the mode has left 11 and returned to it.
- R11: Reserved opcode 1 changes nothing except the PC, whatever its operand field holds.
- R12: The accumulator and registers 0–13 keep their values from one run to the next.
- R13: After reset, done is 1, the accumulator is 0, and ser_req and fc_reload are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_mode | input | 2 | 00 none, 10 load program, 01 load registers, 11 run |
| ld_valid | input | 1 | Load strobe, one write per cycle high |
| ld_addr | input | 4 | Load destination address |
| ld_data | input | 8 | Load data byte |
| done | output | 1 | High while the core is idle |
| acc_value | output | 8 | Current accumulator contents |
| ser_req | output | 1 | One-cycle serial transfer request |
| ser_wr | output | 1 | Transfer direction, 1 = send |
| ser_wdata | output | 8 | Byte to send |
| ser_busy | input | 1 | Serial engine busy |
| ser_rdata | input | 8 | Serial engine receive byte |
| fc_flag | input | 1 | Frame timer flag |
| fc_reload | output | 1 | Frame timer reload strobe |

## Verification
The assertions take for granted that the serial engine raises ser_busy in the cycle right after a request and keeps it high until the transfer ends. The pc-hold check depends on this. The bench's engine model obeys it exactly: it sets busy on the edge that sees ser_req and holds it for a fixed count. The assertions also assume the mode input does not return to 11 during a run, and that load strobes arrive only while the core is idle. The bench changes the mode only between runs, so both assumptions hold.

// File: rtl/tacc_pkg.sv
package tacc_pkg;

    localparam int unsigned WORD_W   = 8;
    localparam int unsigned FIELD_W  = 4;
    localparam int unsigned DEPTH    = 1 << FIELD_W;
    localparam int unsigned N_WRITABLE = DEPTH - 2;
    localparam logic [FIELD_W-1:0] IDX_SER   = FIELD_W'(DEPTH - 2);
    localparam logic [FIELD_W-1:0] IDX_FRAME = FIELD_W'(DEPTH - 1);

    typedef enum logic [3:0] {
        OP_ADD  = 4'h0,
        OP_RSV  = 4'h1,
        OP_AND  = 4'h2,
        OP_LA   = 4'h3,
        OP_OR   = 4'h4,
        OP_XOR  = 4'h5,
        OP_SRL  = 4'h6,
        OP_SLL  = 4'h7,
        OP_ADDI = 4'h8,
        OP_LI   = 4'h9,
        OP_SOUT = 4'hA,
        OP_SIN  = 4'hB,
        OP_SA   = 4'hC,
        OP_BNEZ = 4'hD,
        OP_BEQZ = 4'hE,
        OP_JMP  = 4'hF
    } opcode_e;

    typedef enum logic [1:0] {
        MODE_NONE = 2'b00,
        MODE_RF   = 2'b01,
        MODE_PROG = 2'b10,
        MODE_RUN  = 2'b11
    } mode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } state_e;

    typedef struct packed {
        opcode_e              op;
        logic [FIELD_W-1:0]   fld;
        logic                 imm_sel;
        logic                 acc_we;
        logic                 rf_we;
        logic                 serial;
        logic                 ser_dir;
        logic                 branch;
    } dec_t;

    function automatic logic [WORD_W-1:0] sext_field(input logic [FIELD_W-1:0] f);
        return {{(WORD_W-FIELD_W){f[FIELD_W-1]}}, f};
    endfunction

    function automatic dec_t decode(input logic [WORD_W-1:0] instr);
        dec_t d;
        d.op      = opcode_e'(instr[3:0]);
        d.fld     = instr[WORD_W-1:FIELD_W];
        d.imm_sel = 1'b0;
        d.acc_we  = 1'b0;
        d.rf_we   = 1'b0;
        d.serial  = 1'b0;
        d.ser_dir = 1'b0;
        d.branch  = 1'b0;
        case (d.op)
            OP_ADD, OP_AND, OP_LA, OP_OR, OP_XOR, OP_SRL, OP_SLL: d.acc_we = 1'b1;
            OP_ADDI, OP_LI: begin
                d.acc_we  = 1'b1;
                d.imm_sel = 1'b1;
            end
            OP_SOUT: begin
                d.serial  = 1'b1;
                d.ser_dir = 1'b1;
            end
            OP_SIN:  d.serial = 1'b1;
            OP_SA:   d.rf_we  = 1'b1;
            OP_BNEZ, OP_BEQZ, OP_JMP: d.branch = 1'b1;
            default: ;
        endcase
        return d;
    endfunction

    function automatic logic [WORD_W-1:0] alu_exec(input opcode_e op,
                                                   input logic [WORD_W-1:0] a,
                                                   input logic [WORD_W-1:0] b);
        logic [WORD_W-1:0] r;
        case (op)
            OP_ADD, OP_ADDI: r = a + b;
            OP_AND:          r = a & b;
            OP_OR:           r = a | b;
            OP_XOR:          r = a ^ b;
            OP_LA, OP_LI:    r = b;
            OP_SRL:          r = a >> b[2:0];
            OP_SLL:          r = a << b[2:0];
            default:         r = a;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/tacc_imem.sv
module tacc_imem
    import tacc_pkg::*;
#(
    parameter int unsigned DEPTH_P = DEPTH,
    parameter int unsigned W_P     = WORD_W,
    localparam int unsigned AW     = $clog2(DEPTH_P)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W_P-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [W_P-1:0] rdata
);

    logic [W_P-1:0] mem_q [DEPTH_P];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(DEPTH_P); i++) mem_q[i] <= '0;
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/tacc_regfile.sv
module tacc_regfile
    import tacc_pkg::*;
#(
    parameter int unsigned DEPTH_P = DEPTH,
    parameter int unsigned NWR_P   = N_WRITABLE,
    parameter int unsigned W_P     = WORD_W,
    localparam int unsigned AW     = $clog2(DEPTH_P)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W_P-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [W_P-1:0] rdata
);

    logic [W_P-1:0] reg_q [NWR_P];

    generate
        for (genvar g = 0; g < int'(NWR_P); g++) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) reg_q[g] <= '0;
                else if (we && waddr == AW'(g)) reg_q[g] <= wdata;
            end
        end
    endgenerate

    always_comb begin
        rdata = '0;
        for (int i = 0; i < int'(NWR_P); i++) begin
            if (raddr == AW'(i)) rdata = reg_q[i];
        end
    end

endmodule

// File: rtl/tacc_seq.sv
module tacc_seq
    import tacc_pkg::*;
#(
    parameter int unsigned DEPTH_P = DEPTH,
    localparam int unsigned AW     = $clog2(DEPTH_P),
    localparam logic [AW-1:0] LAST = AW'(DEPTH_P - 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    mode,
    input  logic          is_serial,
    input  logic          br_taken,
    input  logic [AW-1:0] br_target,
    input  logic          ser_busy,
    output logic [AW-1:0] pc,
    output logic          running,
    output logic          retire,
    output logic          ser_req
);

    state_e        state_q;
    logic [AW-1:0] pc_q;
    logic          armed_q;
    logic          issued_q;
    logic          start;

    assign running = (state_q == ST_RUN);
    assign start   = (state_q == ST_IDLE) && (mode == MODE_RUN) && armed_q;
    assign ser_req = running && is_serial && !issued_q;
    assign retire  = running && (!is_serial || (issued_q && !ser_busy));
    assign pc      = pc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            pc_q     <= '0;
            armed_q  <= 1'b1;
            issued_q <= 1'b0;
        end else begin
            if (mode != MODE_RUN) armed_q <= 1'b1;
            else if (start)       armed_q <= 1'b0;

            if (start) begin
                state_q  <= ST_RUN;
                pc_q     <= '0;
                issued_q <= 1'b0;
            end else if (running) begin
                if (ser_req) issued_q <= 1'b1;
                if (retire) begin
                    issued_q <= 1'b0;
                    if (br_taken) begin
                        pc_q <= br_target;
                    end else begin
                        pc_q <= pc_q + 1'b1;
                        if (pc_q == LAST) state_q <= ST_IDLE;
                    end
                end
            end
        end
    end

    AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
        ser_req |=> !ser_req);                                          // R7
    AST_PC_HOLD_BUSY: assert property (@(posedge clk) disable iff (rst)
        (running && issued_q && ser_busy) |=> $stable(pc_q));           // R7
    AST_START_PC0: assert property (@(posedge clk) disable iff (rst)
        $rose(running) |-> (pc_q == '0));                               // R9

endmodule

// File: rtl/tacc_core.sv
module tacc_core
    import tacc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [1:0]          ctrl_mode,
    input  logic                ld_valid,
    input  logic [FIELD_W-1:0]  ld_addr,
    input  logic [WORD_W-1:0]   ld_data,
    output logic                done,
    output logic [WORD_W-1:0]   acc_value,
    output logic                ser_req,
    output logic                ser_wr,
    output logic [WORD_W-1:0]   ser_wdata,
    input  logic                ser_busy,
    input  logic [WORD_W-1:0]   ser_rdata,
    input  logic                fc_flag,
    output logic                fc_reload
);

    logic [FIELD_W-1:0] pc;
    logic               running;
    logic               retire;
    logic [WORD_W-1:0]  instr;
    dec_t               dec;
    logic [WORD_W-1:0]  acc_q;
    logic [WORD_W-1:0]  rf_rdata;
    logic [WORD_W-1:0]  src_val;
    logic [WORD_W-1:0]  opnd;
    logic               br_taken;
    logic               imem_we;
    logic               rf_we;
    logic [FIELD_W-1:0] rf_waddr;
    logic [WORD_W-1:0]  rf_wdata;

    assign dec = decode(instr);

    assign imem_we = ld_valid && !running && (ctrl_mode == MODE_PROG);

    always_comb begin
        if (running) begin
            rf_we    = retire && dec.rf_we;
            rf_waddr = dec.fld;
            rf_wdata = acc_q;
        end else begin
            rf_we    = ld_valid && (ctrl_mode == MODE_RF);
            rf_waddr = ld_addr;
            rf_wdata = ld_data;
        end
    end

    tacc_imem u_imem (
        .clk   (clk),
        .rst   (rst),
        .we    (imem_we),
        .waddr (ld_addr),
        .wdata (ld_data),
        .raddr (pc),
        .rdata (instr)
    );

    tacc_regfile u_rf (
        .clk   (clk),
        .rst   (rst),
        .we    (rf_we),
        .waddr (rf_waddr),
        .wdata (rf_wdata),
        .raddr (dec.fld),
        .rdata (rf_rdata)
    );

    always_comb begin
        if (dec.fld == IDX_SER)        src_val = ser_rdata;
        else if (dec.fld == IDX_FRAME) src_val = {{(WORD_W-1){1'b0}}, fc_flag};
        else                           src_val = rf_rdata;
    end

    assign opnd = dec.imm_sel ? sext_field(dec.fld) : src_val;

    always_comb begin
        case (dec.op)
            OP_BNEZ: br_taken = (acc_q != '0);
            OP_BEQZ: br_taken = (acc_q == '0);
            OP_JMP:  br_taken = 1'b1;
            default: br_taken = 1'b0;
        endcase
    end

    tacc_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .mode      (ctrl_mode),
        .is_serial (dec.serial),
        .br_taken  (br_taken && dec.branch),
        .br_target (dec.fld),
        .ser_busy  (ser_busy),
        .pc        (pc),
        .running   (running),
        .retire    (retire),
        .ser_req   (ser_req)
    );

    always_ff @(posedge clk) begin
        if (rst) acc_q <= '0;
        else if (retire && dec.acc_we) acc_q <= alu_exec(dec.op, acc_q, opnd);
    end

    assign done      = !running;
    assign acc_value = acc_q;
    assign ser_wr    = dec.ser_dir;
    assign ser_wdata = src_val;
    assign fc_reload = retire && (dec.op == OP_LA) && (dec.fld == IDX_FRAME);

    AST_RELOAD_IN_RUN: assert property (@(posedge clk) disable iff (rst)
        fc_reload |-> !done);                                           // R8
    AST_DONE_STAY: assert property (@(posedge clk) disable iff (rst)
        (done && ctrl_mode != MODE_RUN) |=> done);                      // R10
    AST_ACC_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        done |=> $stable(acc_q));                                       // R12
    AST_REQ_IN_RUN: assert property (@(posedge clk) disable iff (rst)
        ser_req |-> !done);                                             // R7

endmodule

// File: tb/tacc_core_tb.sv
module tacc_core_tb;

    localparam int BUSY_CYC = 4;
    localparam int WDOG     = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] ctrl_mode = 2'b00;
    logic       ld_valid = 1'b0;
    logic [3:0] ld_addr = '0;
    logic [7:0] ld_data = '0;
    logic       done;
    logic [7:0] acc_value;
    logic       ser_req, ser_wr;
    logic [7:0] ser_wdata;
    logic       ser_busy;
    logic [7:0] ser_rdata;
    logic       fc_flag = 1'b0;
    logic       fc_reload;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc_total = 0;
    logic [7:0] stub_byte = 8'h00;
    logic [7:0] sent_byte;
    int n_sent = 0;
    int n_reload = 0;
    int busy_cnt;

    always #2.5 clk = ~clk;

    tacc_core u_dut (
        .clk(clk), .rst(rst), .ctrl_mode(ctrl_mode), .ld_valid(ld_valid),
        .ld_addr(ld_addr), .ld_data(ld_data), .done(done), .acc_value(acc_value),
        .ser_req(ser_req), .ser_wr(ser_wr), .ser_wdata(ser_wdata),
        .ser_busy(ser_busy), .ser_rdata(ser_rdata), .fc_flag(fc_flag),
        .fc_reload(fc_reload)
    );

    assign ser_rdata = stub_byte;

    // serial engine model: busy from the edge after a request for BUSY_CYC cycles
    always @(posedge clk) begin
        cyc_total <= cyc_total + 1;
        if (rst) begin
            ser_busy  <= 1'b0;
            busy_cnt  <= 0;
            sent_byte <= 8'h00;
        end else if (ser_req) begin
            ser_busy <= 1'b1;
            busy_cnt <= BUSY_CYC - 1;
            if (ser_wr) begin
                sent_byte <= ser_wdata;
                n_sent    <= n_sent + 1;
            end
        end else if (ser_busy) begin
            if (busy_cnt == 0) ser_busy <= 1'b0;
            else busy_cnt <= busy_cnt - 1;
        end
        if (!rst && fc_reload) n_reload <= n_reload + 1;
    end

    task automatic check(input string req, input int got, input int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    function automatic logic [7:0] ins(input int op, input int fld);
        return {4'(fld), 4'(op)};
    endfunction

    function automatic logic [7:0] model(input int op, input logic [7:0] a, input logic [7:0] b);
        case (op)
            0: return 8'((int'(a) + int'(b)) % 256);
            2: return a & b;
            3: return b;
            4: return a | b;
            5: return a ^ b;
            6: return a >> (b % 8);
            7: return 8'((int'(a) * (1 << (b % 8))) % 256);
            default: return a;
        endcase
    endfunction

    task automatic load(input logic [1:0] m, input int a, input logic [7:0] d);
        @(negedge clk);
        ctrl_mode = m; ld_addr = 4'(a); ld_data = d; ld_valid = 1'b1;
        @(negedge clk);
        ld_valid = 1'b0;
    endtask

    task automatic fill_nops();
        for (int i = 0; i < 16; i++) load(2'b10, i, 8'h01);
    endtask

    task automatic run_prog(output int cyc);
        int guard;
        cyc = 0; guard = 0;
        @(negedge clk);
        ctrl_mode = 2'b11;
        @(negedge clk);
        while (!done && guard < 2000) begin
            cyc++; guard++;
            @(negedge clk);
        end
        ctrl_mode = 2'b00;
        @(negedge clk);
    endtask

    initial begin
        int c;
        logic [7:0] vals [8];
        int ops [7];
        vals = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hFF, 8'h55, 8'hAA, 8'h3C};
        ops  = '{0, 2, 3, 4, 5, 6, 7};

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R13 reset state
        check("R13 done", done, 1);
        check("R13 acc", acc_value, 0);
        check("R13 req", ser_req, 0);
        check("R13 reload", fc_reload, 0);

        fill_nops();

        // R2 / R1 register-operand sweep
        foreach (ops[k]) begin
            for (int i = 0; i < 8; i++) begin
                for (int j = 0; j < 8; j++) begin
                    load(2'b10, 0, ins(3, 0));
                    load(2'b10, 1, ins(ops[k], 1));
                    load(2'b01, 0, vals[i]);
                    load(2'b01, 1, vals[j]);
                    run_prog(c);
                    check($sformatf("R2 op%0d", ops[k]), acc_value, model(ops[k], vals[i], vals[j]));
                end
            end
        end
        check("R10 run length", c, 16);

        // R3 immediates
        for (int i = 0; i < 8; i++) begin
            for (int f = 0; f < 16; f++) begin
                load(2'b10, 0, ins(3, 0));
                load(2'b10, 1, ins(8, f));
                load(2'b01, 0, vals[i]);
                run_prog(c);
                check("R3 addi", acc_value, (int'(vals[i]) + (f < 8 ? f : f + 240)) % 256);
            end
        end
        for (int f = 0; f < 16; f++) begin
            load(2'b10, 0, ins(9, f));
            load(2'b10, 1, 8'h01);
            run_prog(c);
            check("R3 li", acc_value, f < 8 ? f : f + 240);
        end

        // R11 reserved opcode with non-zero field
        load(2'b10, 0, ins(9, 6));
        for (int i = 1; i < 16; i++) load(2'b10, i, ins(1, i));
        run_prog(c);
        check("R11 reserved", acc_value, 6);
        fill_nops();

        // R5 R7 R4: store, send, read-only x14, receive
        stub_byte = 8'h6B;
        load(2'b10, 0, ins(9, 13));   // li -3
        load(2'b10, 1, ins(12, 5));   // sa x5
        load(2'b10, 2, ins(10, 5));   // sout x5
        load(2'b10, 3, ins(12, 14));  // sa x14
        load(2'b10, 4, ins(11, 0));   // sin
        load(2'b10, 5, ins(3, 14));   // la x14
        run_prog(c);
        check("R5 sa then send", sent_byte, 8'hFD);
        check("R7 one send", n_sent, 1);
        check("R7 stall length", c, 16 + 2 * (BUSY_CYC + 1));
        check("R4 x14 read", acc_value, 8'h6B);

        // R12 persistence across runs
        fill_nops();
        load(2'b10, 0, ins(10, 5));
        run_prog(c);
        check("R12 x5 kept", sent_byte, 8'hFD);
        check("R12 acc kept", acc_value, 8'h6B);

        // R5 load-mode write to x14 ignored
        load(2'b01, 14, 8'h55);
        stub_byte = 8'h21;
        load(2'b10, 0, ins(3, 14));
        run_prog(c);
        check("R5 x14 read-only", acc_value, 8'h21);

        // R8 R4 frame flag and reload
        fc_flag = 1'b1;
        load(2'b10, 0, ins(3, 15));
        run_prog(c);
        check("R4 x15 flag=1", acc_value, 1);
        check("R8 reload count", n_reload, 1);
        fc_flag = 1'b0;
        load(2'b10, 1, ins(0, 15));
        load(2'b10, 0, ins(9, 4));
        run_prog(c);
        check("R8 no reload from add", n_reload, 1);
        check("R4 x15 flag=0", acc_value, 4);

        // R6 branches
        fill_nops();
        load(2'b10, 0, ins(9, 3));
        load(2'b10, 1, ins(13, 4));
        load(2'b10, 2, ins(9, 7));
        load(2'b10, 4, ins(8, 1));
        load(2'b10, 5, ins(14, 9));
        load(2'b10, 6, ins(9, 0));
        load(2'b10, 7, ins(14, 10));
        load(2'b10, 8, ins(9, 5));
        load(2'b10, 10, ins(8, 2));
        run_prog(c);
        check("R6 branch acc", acc_value, 2);
        check("R6 branch path", c, 12);
        fill_nops();
        load(2'b10, 0, ins(9, 1));
        load(2'b10, 1, ins(15, 3));
        load(2'b10, 2, ins(9, 7));
        run_prog(c);
        check("R6 jmp acc", acc_value, 1);
        check("R6 jmp path", c, 15);

        // R9 mode 00 strobe writes nothing
        load(2'b00, 0, ins(9, 6));
        run_prog(c);
        check("R9 mode00 ignored", acc_value, 1);

        // R10 stays idle while mode held at 11
        @(negedge clk);
        ctrl_mode = 2'b11;
        @(negedge clk);
        check("R10 running", done, 0);
        repeat (40) begin
            @(negedge clk);
        end
        check("R10 stays done", done, 1);
        ctrl_mode = 2'b00;
        @(negedge clk);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        wait (cyc_total > WDOG);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule